// File: doc/BRIEF.md
# Preloadable Timer / Event Counter with Pulse-Width Capture

An up-counter of 8 or 16 bits with a preload register, a byte-wide register bus and an overflow interrupt. The counter has three counting modes. Event mode counts the selected edge of an external pin. Timer mode counts cycles in which an internal tick enable is high. Pulse-width mode measures one pulse on the external pin, in internal ticks, and then stops itself.

When the counter passes all-ones it reloads from the preload register. It also sets a sticky interrupt flag and gives a one-cycle wake pulse. The interrupt output is the flag ANDed with an enable bit. A write to the preload register loads the counter as well only when the counter is stopped. In the 16-bit form, reading the high byte copies the low byte into a holding buffer, so the two byte reads return one consistent value.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, the preload register and the control register read zero, and irq and wake are low.
- R2: The bus addresses are 0 for the low byte, 1 for the high byte and 2 for control. A preload write while the run bit (control bit 4) is 0 also loads the counter. A preload write while run is 1 changes only the preload value, and the counter takes that value at its next overflow.
- R3: In timer mode (control bits 7:6 = 10) with run set, the counter increments once for every cycle in which tick_en is high.
- R4: In event mode (bits 7:6 = 01) with run set, the counter increments once for each edge of the synchronised pin. Rising edges count when the edge bit (bit 3) is 1, and falling edges count when it is 0.
- R5: An increment from all-ones reloads the counter from preload, sets the flag (bit 5) and raises wake for one cycle. In event and timer modes the run bit stays set.
- R6: irq equals the flag ANDed with the enable bit (bit 2). Writing 0 to bit 5 clears the flag. Writing 1 to bit 5 has no effect.
- R7: In pulse-width mode (bits 7:6 = 11) with run set, a measurement starts on the active edge selected by bit 3. While the pin stays at the active level the counter counts tick_en cycles. When the pin returns to the other level, run clears and the count is held.
- R8: After a measurement completes, further pin edges and ticks leave the counter unchanged until run is written to 1 again.
- R9: If the pin is already at the active level when pulse-width mode is armed, nothing is counted until a fresh active edge arrives.
- R10: An overflow during a pulse-width measurement reloads from preload and sets the flag, as in the other modes.
- R11: Reading address 1 returns the counter high byte and, in the same cycle, stores the counter low byte. A following read of address 0 returns that stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal count enable for timer and pulse-width modes |
| ext_pin | input | 1 | External asynchronous input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; drives the low-byte latch |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request (flag and enable) |
| wake | output | 1 | One-cycle pulse on each overflow |

## Verification
The assertions assume that each bus strobe lasts exactly one clock. They also assume that only one register access happens per cycle and that the pin changes slowly enough for the three-flop sampler to catch each level. The bench drives all inputs one time unit after a rising edge and raises each strobe for a single edge. It holds the pin steady for four cycles after every change, and it pulses tick_en one cycle at a time, so every count is exact.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ext_pin,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       wake
);
  localparam bit WIDE = (WIDTH > 8);
  localparam logic [WIDTH-1:0] ALL1 = '1;
  localparam logic [1:0] M_EVT = 2'b01, M_TMR = 2'b10, M_PW = 2'b11;

  logic [WIDTH-1:0] cnt;
  logic [15:0] pre16, pre_nxt, cnt16;
  logic [7:0]  lo_buf;
  logic [1:0]  mode;
  logic        run, edge_sel, ie, flag_q, meas;
  logic [2:0]  sy;

  wire pin_s    = sy[1];
  wire pin_d    = sy[2];
  wire lvl_act  = edge_sel ? pin_s : ~pin_s;
  wire act_edge = edge_sel ? (pin_s & ~pin_d) : (~pin_s & pin_d);
  wire ctl_wr   = bus_wr & (bus_addr == 2'd2);
  wire pre_wr   = bus_wr & ((bus_addr == 2'd0) | (WIDE & (bus_addr == 2'd1)));
  wire inc      = run & (((mode == M_EVT) & act_edge) |
                         ((mode == M_TMR) & tick_en) |
                         ((mode == M_PW) & meas & lvl_act & tick_en));
  wire ovf      = inc & (cnt == ALL1);
  wire pw_done  = (mode == M_PW) & run & meas & ~lvl_act;

  assign cnt16 = 16'(cnt);
  assign irq   = flag_q & ie;

  always_comb begin
    pre_nxt = pre16;
    if (bus_wr && bus_addr == 2'd0) pre_nxt[7:0] = bus_wdata;
    if (bus_wr && bus_addr == 2'd1 && WIDE) pre_nxt[15:8] = bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = WIDE ? lo_buf : cnt16[7:0];
      2'd1:    bus_rdata = WIDE ? cnt16[15:8] : 8'h00;
      2'd2:    bus_rdata = {mode, flag_q, run, edge_sel, ie, 2'b00};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre16 <= '0; lo_buf <= '0; wake <= 1'b0; flag_q <= 1'b0;
      mode <= '0; run <= 1'b0; edge_sel <= 1'b0; ie <= 1'b0; meas <= 1'b0;
    end else begin
      pre16 <= pre_nxt;
      if (pre_wr && !run) cnt <= pre_nxt[WIDTH-1:0];
      else if (ovf)       cnt <= pre16[WIDTH-1:0];
      else if (inc)       cnt <= cnt + 1'b1;
      wake <= ovf;
      if (ovf)         flag_q <= 1'b1;
      else if (ctl_wr) flag_q <= flag_q & bus_wdata[5];
      if (ctl_wr) begin
        mode <= bus_wdata[7:6]; run <= bus_wdata[4];
        edge_sel <= bus_wdata[3]; ie <= bus_wdata[2]; meas <= 1'b0;
      end else if (pw_done) begin
        run <= 1'b0; meas <= 1'b0;
      end else if (mode == M_PW && run && !meas && act_edge) begin
        meas <= 1'b1;
      end
      if (bus_rd && bus_addr == 2'd1 && WIDE) lo_buf <= cnt16[7:0];
    end
  end

  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == $past(pre16[WIDTH-1:0])) && flag_q && wake);
  // R5
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> flag_q);
  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(ovf));
  // R7
  meas_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas |-> run);
  // R8
  held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr) |=> $stable(cnt));
endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb_top;
  logic clk = 0, rst_n = 0, tick_en = 0, ext_pin = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq, wake;
  int tests = 0, fails = 0, wake_n = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  evt_timer #(.WIDTH(16)) dut_i (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ext_pin(ext_pin), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (wake) wake_n++;
    if (bus_rd) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++; $display("FAIL scoreboard empty, got %h", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++; $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask
  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1 bus_rd = 1; bus_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 bus_rd = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick_en = 1;
      @(posedge clk); #1 tick_en = 0;
    end
  endtask
  task automatic pin(input logic v);
    @(posedge clk); #1 ext_pin = v;
    repeat (4) @(posedge clk);
  endtask
  task automatic chk(input string t, input int act, input int e);
    @(negedge clk); tests++;
    if (act != e) begin fails++; $display("FAIL %s: got %0d expected %0d", t, act, e); end
  endtask
  task automatic rd16(input logic [15:0] e, input string t);
    rd(2'd1, e[15:8], t); rd(2'd0, e[7:0], t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset state
    rd(2'd2, 8'h00, "R1 ctrl"); rd16(16'h0000, "R1 counter");
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
    // R6 writing 1 to flag does not set it
    wr(2'd2, 8'h20); rd(2'd2, 8'h00, "R6 flag write 1");
    // R2 stopped write loads counter; R11 coherent read
    wr(2'd0, 8'hF0); wr(2'd1, 8'hFF); rd16(16'hFFF0, "R2 R11 stopped load");
    // R3 timer mode
    wr(2'd2, 8'h94); ticks(5); rd16(16'hFFF5, "R3 timer count");
    ticks(11); rd16(16'hFFF0, "R5 reload");
    chk("R6 irq set", irq, 1); chk("R5 wake count", wake_n, 1);
    rd(2'd2, 8'hB4, "R5 run kept");
    // R2 running write only preload
    wr(2'd0, 8'h00); wr(2'd1, 8'h80); rd16(16'hFFF0, "R2 running write");
    ticks(16); rd16(16'h8000, "R2 new preload at overflow");
    // R6 clear flag, then overflow with enable off
    wr(2'd2, 8'h94); chk("R6 irq cleared", irq, 0);
    wr(2'd2, 8'h80); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h90); ticks(2);
    chk("R6 irq masked", irq, 0); rd(2'd2, 8'hB0, "R6 flag set masked");
    rd16(16'hFFFE, "R5 reload masked");
    // R4 event mode
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h58);
    for (int i = 0; i < 3; i++) begin pin(1); pin(0); end
    rd16(16'h0003, "R4 rising edges");
    wr(2'd2, 8'h50);
    for (int i = 0; i < 2; i++) begin pin(1); pin(0); end
    rd16(16'h0005, "R4 falling edges");
    // R7 pulse width
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'hD8); pin(1); ticks(7); pin(0);
    rd(2'd2, 8'hC8, "R7 run cleared"); rd16(16'h0007, "R7 width");
    // R8 one shot
    pin(1); ticks(3); pin(0); rd16(16'h0007, "R8 ignored after done");
    // R9 armed at active level
    pin(1); wr(2'd2, 8'hD8); ticks(5);
    rd16(16'h0007, "R9 no count at level"); rd(2'd2, 8'hD8, "R9 still armed");
    // R10 overflow in pulse mode, falling-edge active
    wr(2'd2, 8'h00); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd2, 8'hD4); pin(0); ticks(3); pin(1);
    rd(2'd2, 8'hE4, "R10 flag and run"); rd16(16'hFFFF, "R10 reload count");
    chk("R10 irq", irq, 1); chk("R5 wake total", wake_n, 4);
    repeat (2) @(posedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule